// File: doc/BRIEF.md
# Mode-Strapped 8-Bit GPIO Port Registers

This block is the register side of one 8-bit general-purpose I/O port on a simple processor bus. It holds two registers. The direction register sets, bit by bit, whether a pin drives or listens. The output register holds the value that output pins drive. The block drives per-pin output enables and output values. It also brings the pin levels back to the bus through a two-stage synchronizer.

The operating mode is strapped on `mode_i` and is captured only while reset is held. Modes 3, 4 and 6 use the top pin as an address output. In those modes direction bit 7 comes out of reset as 1 and no write can clear it. Every other mode code leaves it free. Hardware standby returns both registers to their reset values. Software standby freezes them, so every pin set as an output keeps driving its last value.

Top module: `gpio_port_regs`

## Requirements
- R1: A bus write to address 0xFFD1 loads the direction register, and `pin_oe_o` bit n is 1 (output) exactly when direction bit n is 1.
- R2: A read of address 0xFFD1 returns 0xFF whatever the direction register holds (the register is write-only).
- R3: After reset in mode 0, 1, 2, 5, 7 or any code 8 to 15, the direction register is 0x00.
- R4: After reset in mode 3, 4 or 6, the direction register is 0x80, and bit 7 stays 1 after any write.
- R5: A bus write to address 0xFFD3 loads the output register, which drives `pin_o` and is 0x00 after reset in every mode.
- R6: A read of 0xFFD3 returns, for each bit, the output register bit when the pin is an output and the synchronized pin level when it is an input. A pin change becomes visible on the second rising clock edge after it is applied, and not on the first.
- R7: While `sw_stby_i` is 1 and `hw_stby_i` is 0, bus writes are ignored and `pin_oe_o` and `pin_o` keep their values.
- R8: A clock edge with `hw_stby_i` at 1 returns the direction register to its mode reset value and the output register to 0x00. This takes priority over writes and software standby.
- R9: Writes to any other address change neither register. Reads of any other address, and any bus cycle without `bus_sel_i`, return 0x00.
- R10: `mode_i` is sampled only while reset is active. A change after reset does not move the bit-7 lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Strapped operating mode |
| hw_stby_i | input | 1 | Hardware standby, reinitializes registers |
| sw_stby_i | input | 1 | Software standby, freezes registers |
| bus_sel_i | input | 1 | Bus cycle targets this block |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Low 16 address bits |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| pin_i | input | 8 | Pin levels from the pads |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_o | output | 8 | Per-pin output value |

## Verification
On every cycle, the assertions check four things: direction writes reaching `pin_oe_o`, the bit-7 lock in address modes, the all-ones read of the direction address, and the hold and reinitialize rules for the two standby inputs. They also check that the captured mode stays frozen after reset. Only the bench scenarios can show the per-mode reset values across the mode codes, including the out-of-range ones. The same holds for the two-edge latency of pin read-back, the mixed output and input read-back, and the fact that a mode change after reset has no effect.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int MODE_W = 4;

  // Modes in which the top pin carries an address bit and its direction is pinned high.
  function automatic logic mode_locks_msb(input logic [MODE_W-1:0] m);
    case (m)
      4'd3, 4'd4, 4'd6: mode_locks_msb = 1'b1;
      default:          mode_locks_msb = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_mode_latch.sv
module gpio_mode_latch
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              capture_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              lock_msb_o
);
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] mode_d;

  // Strap register: loaded on every edge while reset is held, frozen afterwards.
  always_comb begin
    mode_d = mode_q;
    if (capture_i) mode_d = mode_i;
  end

  always_ff @(posedge clk) begin
    if (capture_i) mode_q <= mode_d;
  end

  assign lock_msb_o = mode_locks_msb(mode_q);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int              WIDTH       = 8,
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFD1,
  parameter logic [ADDR_W-1:0] OUT_ADDR  = 16'hFFD3,
  parameter int              SYNC_STAGES = 2,
  parameter int              RST_STAGES  = 2,
  parameter int              LOCK_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WIDTH-1:0]  bus_wdata_i,
  output logic [WIDTH-1:0]  bus_rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic [WIDTH-1:0]  pin_o
);
  localparam logic [WIDTH-1:0] LOCK_MASK = WIDTH'(1) << LOCK_BIT;
  localparam logic [WIDTH-1:0] ALL_ONES  = '1;

  logic             rst_sync_n;
  logic             lock_msb;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q, dir_d, out_q, out_d;
  logic             dir_en, out_en;
  logic [WIDTH-1:0] dir_eff;
  logic             hit_dir_wr, hit_out_wr, hit_dir_rd, hit_out_rd;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gpio_mode_latch u_mode (
    .clk(clk), .capture_i(!rst_sync_n), .mode_i(mode_i), .lock_msb_o(lock_msb)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(pin_i), .q_o(pin_sync)
  );

  assign hit_dir_wr = bus_sel_i &  bus_wr_i & (bus_addr_i == DIR_ADDR);
  assign hit_out_wr = bus_sel_i &  bus_wr_i & (bus_addr_i == OUT_ADDR);
  assign hit_dir_rd = bus_sel_i & !bus_wr_i & (bus_addr_i == DIR_ADDR);
  assign hit_out_rd = bus_sel_i & !bus_wr_i & (bus_addr_i == OUT_ADDR);

  // Next state: hardware standby first, then software standby freeze, then bus writes.
  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    dir_en = 1'b0;
    out_en = 1'b0;
    if (hw_stby_i) begin
      dir_d  = '0;
      out_d  = '0;
      dir_en = 1'b1;
      out_en = 1'b1;
    end else if (!sw_stby_i) begin
      if (hit_dir_wr) begin
        dir_d  = bus_wdata_i;
        dir_en = 1'b1;
      end
      if (hit_out_wr) begin
        out_d  = bus_wdata_i;
        out_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  dir_q <= '0;
    else if (dir_en)  dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  out_q <= '0;
    else if (out_en)  out_q <= out_d;
  end

  // The locked bit is forced at the output, so a stored 0 can never clear it.
  assign dir_eff  = dir_q | (lock_msb ? LOCK_MASK : '0);
  assign pin_oe_o = dir_eff;
  assign pin_o    = out_q;

  always_comb begin
    bus_rdata_o = '0;
    if (hit_dir_rd)      bus_rdata_o = ALL_ONES;
    else if (hit_out_rd) bus_rdata_o = (out_q & dir_eff) | (pin_sync & ~dir_eff);
  end

  a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit_dir_wr && !hw_stby_i && !sw_stby_i) |=>
      ((pin_oe_o & ~LOCK_MASK) == ($past(bus_wdata_i) & ~LOCK_MASK)));

  a_r2_dir_reads_ones: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_dir_rd |-> (bus_rdata_o == ALL_ONES));

  a_r4_msb_locked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_msb |-> pin_oe_o[LOCK_BIT]);

  a_r7_sw_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sw_stby_i && !hw_stby_i) |=>
      (pin_oe_o == $past(pin_oe_o)) && (pin_o == $past(pin_o)));

  a_r8_hw_init: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hw_stby_i |=> (pin_o == '0) && ((pin_oe_o & ~LOCK_MASK) == '0));

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(!rst_sync_n) |-> $stable(lock_msb));
endmodule

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mode_i;
  logic       hw, sw, sel, wr;
  logic [15:0] addr;
  logic [7:0] wdata, rdata, pin, oe, pout;

  int checks = 0;
  int errors = 0;

  // Reference state
  bit       valid = 1'b0;
  bit       m_lock;
  logic [7:0] m_dir, m_out, m_s1, m_s2;

  always #10 clk = ~clk;

  gpio_port_regs u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .hw_stby_i(hw), .sw_stby_i(sw),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .pin_i(pin), .pin_oe_o(oe), .pin_o(pout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_oe();
    return m_dir | (m_lock ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [7:0] m_rd();
    if (!sel || wr)         return 8'h00;
    if (addr == 16'hFFD1)   return 8'hFF;
    if (addr == 16'hFFD3)   return (m_out & m_oe()) | (m_s2 & ~m_oe());
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (valid) begin
      if (hw) begin
        m_dir = 8'h00; m_out = 8'h00;
      end else if (!sw && sel && wr) begin
        if (addr == 16'hFFD1) m_dir = wdata;
        if (addr == 16'hFFD3) m_out = wdata;
      end
      m_s2 = m_s1;
      m_s1 = pin;
    end
  end

  always @(negedge clk) begin
    if (valid) begin
      chk(oe == m_oe(),     "model R1/R4 pin_oe", oe, m_oe());
      chk(pout == m_out,    "model R5 pin_o", pout, m_out);
      chk(rdata == m_rd(),  "model R6/R9 rdata", rdata, m_rd());
    end
  end

  task automatic do_reset(input logic [3:0] m);
    valid = 1'b0;
    @(negedge clk); #1;
    rst_n = 1'b0; mode_i = m;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    m_lock = (m == 4'd3) || (m == 4'd4) || (m == 4'd6);
    m_dir = 8'h00; m_out = 8'h00; m_s1 = pin; m_s2 = pin;
    valid = 1'b1;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); #1;
    sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; mode_i = 4'd1; hw = 1'b0; sw = 1'b0; sel = 1'b0; wr = 1'b0;
    addr = '0; wdata = '0; pin = 8'h5A;

    // Mode 1 reset values
    do_reset(4'd1);
    chk(oe == 8'h00,   "R3 mode1 dir reset", oe, 8'h00);
    chk(pout == 8'h00, "R5 out reset", pout, 8'h00);
    bus_read(16'hFFD1, rv);
    chk(rv == 8'hFF,   "R2 dir read all ones", rv, 8'hFF);

    // Direction and output writes, mixed read-back
    bus_write(16'hFFD1, 8'h0F);
    chk(oe == 8'h0F,   "R1 dir write", oe, 8'h0F);
    bus_write(16'hFFD3, 8'hA5);
    chk(pout == 8'hA5, "R5 out write", pout, 8'hA5);
    bus_read(16'hFFD3, rv);
    chk(rv == 8'h55,   "R6 mixed readback", rv, 8'h55);

    // Two-edge input latency
    @(negedge clk); #1;
    pin = 8'hC3; sel = 1'b1; wr = 1'b0; addr = 16'hFFD3;
    @(negedge clk); #2;
    chk(rdata == 8'h55, "R6 not visible after one edge", rdata, 8'h55);
    @(negedge clk); #2;
    chk(rdata == 8'hC5, "R6 visible after two edges", rdata, 8'hC5);
    #1 sel = 1'b0;

    // Other addresses
    bus_write(16'hFFD2, 8'hFF);
    bus_write(16'hFFD5, 8'h00);
    chk(oe == 8'h0F && pout == 8'hA5, "R9 stray write ignored", {oe, pout}, 16'h0FA5);
    bus_read(16'hFFD5, rv);
    chk(rv == 8'h00, "R9 stray read zero", rv, 8'h00);
    @(negedge clk); #1 sel = 1'b0; wr = 1'b0; addr = 16'hFFD1;
    #1 chk(rdata == 8'h00, "R9 unselected read zero", rdata, 8'h00);

    // Software standby freeze
    @(negedge clk); #1 sw = 1'b1;
    bus_write(16'hFFD1, 8'hF0);
    bus_write(16'hFFD3, 8'h00);
    chk(oe == 8'h0F,   "R7 dir held in sw standby", oe, 8'h0F);
    chk(pout == 8'hA5, "R7 out held in sw standby", pout, 8'hA5);
    @(negedge clk); #1 sw = 1'b0;

    // Hardware standby reinit, taking priority over a write
    @(negedge clk); #1 hw = 1'b1; sel = 1'b1; wr = 1'b1; addr = 16'hFFD3; wdata = 8'h77;
    @(negedge clk); #1 hw = 1'b0; sel = 1'b0; wr = 1'b0;
    chk(oe == 8'h00,   "R8 hw dir reinit", oe, 8'h00);
    chk(pout == 8'h00, "R8 hw out cleared", pout, 8'h00);

    // Mode change after reset has no effect
    @(negedge clk); #1 mode_i = 4'd3;
    bus_write(16'hFFD1, 8'h00);
    chk(oe == 8'h00, "R10 mode change ignored", oe, 8'h00);

    // Address modes
    do_reset(4'd3);
    chk(oe == 8'h80, "R4 mode3 dir reset", oe, 8'h80);
    bus_write(16'hFFD1, 8'h01);
    chk(oe == 8'h81, "R4 bit7 stays set", oe, 8'h81);
    @(negedge clk); #1 hw = 1'b1;
    @(negedge clk); #1 hw = 1'b0;
    chk(oe == 8'h80, "R8 hw reinit mode3", oe, 8'h80);
    bus_read(16'hFFD1, rv);
    chk(rv == 8'hFF, "R2 dir read mode3", rv, 8'hFF);

    do_reset(4'd6);
    chk(oe == 8'h80, "R4 mode6 dir reset", oe, 8'h80);
    do_reset(4'd4);
    chk(oe == 8'h80, "R4 mode4 dir reset", oe, 8'h80);
    do_reset(4'd0);
    chk(oe == 8'h00, "R3 mode0 dir reset", oe, 8'h00);
    do_reset(4'd9);
    chk(oe == 8'h00, "R3 mode9 dir reset", oe, 8'h00);
    bus_write(16'hFFD1, 8'h00);
    chk(oe == 8'h00, "R3 mode9 bit7 clearable", oe, 8'h00);
    do_reset(4'd7);
    chk(oe == 8'h00, "R3 mode7 dir reset", oe, 8'h00);
    chk(pout == 8'h00, "R5 out reset mode7", pout, 8'h00);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule